// File: doc/BRIEF.md
# Trigger Input Conditioning Filter

This block cleans up trigger inputs before they reach timers, converters or other logic. It does so for a parameterised number of independent channels, 28 by default. Each channel takes one raw, possibly asynchronous trigger line and passes it through three stages. The first is an optional two-flop synchronizer clocked by the module clock. The second is a digital filter with five selectable behaviours. The third is an optional output inversion. The configuration inputs of each channel choose the behaviour, the synchronizer enable, the inversion and the filter length.

The filter length is given as a base count and a power-of-two shift. The effective length is the base shifted left by the shift. Software that needs a long window uses a larger shift and gives up low-order resolution. The filtered level is held in one register per channel, and the output is that register XOR the channel's invert bit.

Top module: `tcf_top`

## Requirements
- R1: While reset is held, every channel's filter register is 0, so each output equals that channel's invert bit.
- R2: Mode code 0 (bypass), and any unused code 5 to 7, copies the conditioned input into the filter register on every clock, so an output follows a raw change one clock later when the synchronizer is off.
- R3: With the synchronizer bit set, a raw change reaches the output three clocks later instead of one.
- R4: The invert bit flips the output after all filtering.
- R5: Mode code 2 (delay) changes the filtered level only after the conditioned input has differed from it on L consecutive clocks, where L is the effective length. Both edges are delayed, and a pulse shorter than L is removed.
- R6: The effective length L is the base count shifted left by the shift field. L of 0 or 1 behaves as a one-clock pass.
- R7: Mode code 1 (rapid change) passes an input edge one clock later. It then ignores input changes on the next L-1 clocks, so the filtered level cannot change again until L clocks after the previous change.
- R8: Mode code 4 (stable high) delays a rising change by L, as in R5. A falling change passes one clock later.
- R9: Mode code 3 (stable low) delays a falling change by L. A rising change passes one clock later.
- R10: If the input returns to the filtered level before L is reached, the length counter restarts from zero.
- R11: On the clock after the mode code changes, the filter register takes the current conditioned input level and the counter clears, whatever the new mode is.
- R12: Channels are independent: the stimulus and configuration of one channel have no effect on another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_raw_i | input | NCH | Raw trigger input, one bit per channel |
| sync_en_i | input | NCH | Per-channel synchronizer enable |
| inv_i | input | NCH | Per-channel output invert |
| mode_i | input | NCH x 3 | Per-channel filter mode code |
| len_base_i | input | NCH x BASE_W | Per-channel length base count |
| len_shift_i | input | NCH x SHIFT_W | Per-channel length shift |
| trig_o | output | NCH | Conditioned trigger output |

## Verification
The assertions expect a channel's raw input to be sampled cleanly at the clock edge whenever its synchronizer is off. They also expect the invert bit, the length fields and the mode code to be stable across the cycles a property looks back over, or else the antecedent excludes those cycles. The bench changes every input, raw triggers included, on the falling clock edge, so each value is settled well before the next rising edge. It holds the configuration fixed while it measures a delay. Every scenario starts from a bypass state with the input low, so the filtered level is known before the mode under test is selected.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    FM_BYPASS = 3'd0,
    FM_RAPID  = 3'd1,
    FM_DELAY  = 3'd2,
    FM_STLOW  = 3'd3,
    FM_STHIGH = 3'd4
  } tcf_mode_e;
endpackage

// File: rtl/tcf_rst_sync.sv
module tcf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/tcf_sync.sv
module tcf_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  input  logic en_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  // route through the two stages only when enabled
  assign q_o = en_i ? s2_q : d_i;
endmodule

// File: rtl/tcf_core.sv
module tcf_core
  import tcf_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              y_o
);
  logic              y_q, y_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W:0]    cnt_inc;
  logic              hit, long_len, mode_chg, st_en;

  assign cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign hit      = cnt_inc >= {1'b0, len_i};
  assign long_len = len_i > CNT_W'(1);
  assign mode_chg = mode_i != mode_q;

  always_comb begin
    y_d   = y_q;
    cnt_d = cnt_q;
    if (mode_chg) begin
      // resynchronise to the present level
      y_d   = x_i;
      cnt_d = '0;
    end else begin
      case (mode_i)
        FM_RAPID: begin
          if (cnt_q != '0) begin
            cnt_d = hit ? '0 : cnt_inc[CNT_W-1:0];
          end else if (x_i != y_q) begin
            y_d   = x_i;
            cnt_d = long_len ? CNT_W'(1) : '0;
          end
        end
        FM_DELAY, FM_STLOW, FM_STHIGH: begin
          if (x_i == y_q) begin
            cnt_d = '0;
          end else if ((mode_i == FM_STHIGH && !x_i) ||
                       (mode_i == FM_STLOW  &&  x_i) || hit) begin
            y_d   = x_i;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        default: begin
          y_d   = x_i;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign st_en = (y_d != y_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q    <= 1'b0;
      cnt_q  <= '0;
      mode_q <= FM_BYPASS;
    end else begin
      mode_q <= mode_i;
      if (st_en) begin
        y_q   <= y_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign y_o = y_q;
endmodule

// File: rtl/tcf_top.sv
module tcf_top
  import tcf_pkg::*;
#(
  parameter int NCH     = 28,
  parameter int BASE_W  = 8,
  parameter int SHIFT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                trig_raw_i,
  input  logic [NCH-1:0]                sync_en_i,
  input  logic [NCH-1:0]                inv_i,
  input  logic [NCH-1:0][MODE_W-1:0]    mode_i,
  input  logic [NCH-1:0][BASE_W-1:0]    len_base_i,
  input  logic [NCH-1:0][SHIFT_W-1:0]   len_shift_i,
  output logic [NCH-1:0]                trig_o
);
  localparam int CNT_W = BASE_W + (1 << SHIFT_W) - 1;

  logic rst_n_int;

  tcf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_int)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic             x_c, y_c;
    logic [CNT_W-1:0] len_c;

    assign len_c = CNT_W'(len_base_i[c]) << len_shift_i[c];

    tcf_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n_int),
      .d_i   (trig_raw_i[c]),
      .en_i  (sync_en_i[c]),
      .q_o   (x_c)
    );

    tcf_core #(.CNT_W(CNT_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .x_i    (x_c),
      .mode_i (mode_i[c]),
      .len_i  (len_c),
      .y_o    (y_c)
    );

    assign trig_o[c] = y_c ^ inv_i[c];
  end
endmodule

// File: rtl/tcf_chk.sv
module tcf_chk
  import tcf_pkg::*;
#(
  parameter int NCH     = 28,
  parameter int BASE_W  = 8,
  parameter int SHIFT_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NCH-1:0]              trig_raw_i,
  input logic [NCH-1:0]              sync_en_i,
  input logic [NCH-1:0]              inv_i,
  input logic [NCH-1:0][MODE_W-1:0]  mode_i,
  input logic [NCH-1:0][BASE_W-1:0]  len_base_i,
  input logic [NCH-1:0][SHIFT_W-1:0] len_shift_i,
  input logic [NCH-1:0]              trig_o
);
  localparam int CNT_W = BASE_W + (1 << SHIFT_W) - 1;

  // high once at least one edge has passed out of reset
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [CNT_W-1:0] len_w;
    logic             lvl;
    assign len_w = CNT_W'(len_base_i[c]) << len_shift_i[c];
    assign lvl   = trig_o[c] ^ inv_i[c];

    // R2
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && $past(mode_i[c]) == FM_BYPASS && !$past(sync_en_i[c]))
      |-> (lvl == $past(trig_raw_i[c])));

    // R8
    sthigh_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && $past(mode_i[c]) == FM_STHIGH && !$past(sync_en_i[c])
       && !$past(trig_raw_i[c]))
      |-> !lvl);

    // R9
    stlow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && $past(mode_i[c]) == FM_STLOW && !$past(sync_en_i[c])
       && $past(trig_raw_i[c]))
      |-> lvl);

    // R5
    delay_no_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && $past(up_q) && $past(mode_i[c]) == FM_DELAY
       && $past(mode_i[c], 2) == FM_DELAY
       && !$past(sync_en_i[c]) && !$past(sync_en_i[c], 2)
       && $past(trig_raw_i[c]) != $past(trig_raw_i[c], 2)
       && $past(len_w) > CNT_W'(1))
      |-> (lvl == $past(lvl)));
  end
endmodule

bind tcf_top tcf_chk #(
  .NCH     (NCH),
  .BASE_W  (BASE_W),
  .SHIFT_W (SHIFT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .trig_raw_i  (trig_raw_i),
  .sync_en_i   (sync_en_i),
  .inv_i       (inv_i),
  .mode_i      (mode_i),
  .len_base_i  (len_base_i),
  .len_shift_i (len_shift_i),
  .trig_o      (trig_o)
);

// File: tb/sim_tcf_top.sv
module sim_tcf_top;
  localparam int NCH = 28;
  localparam int BW  = 8;
  localparam int SW  = 3;

  localparam logic [2:0] MD_BYP = 3'd0;
  localparam logic [2:0] MD_RAP = 3'd1;
  localparam logic [2:0] MD_DLY = 3'd2;
  localparam logic [2:0] MD_SLO = 3'd3;
  localparam logic [2:0] MD_SHI = 3'd4;

  logic                       clk;
  logic                       rst_n;
  logic [NCH-1:0]             raw, syn, inv;
  logic [NCH-1:0][2:0]        mode;
  logic [NCH-1:0][BW-1:0]     base;
  logic [NCH-1:0][SW-1:0]     shf;
  logic [NCH-1:0]             trig;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  tcf_top #(.NCH(NCH), .BASE_W(BW), .SHIFT_W(SW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_raw_i  (raw),
    .sync_en_i   (syn),
    .inv_i       (inv),
    .mode_i      (mode),
    .len_base_i  (base),
    .len_shift_i (shf),
    .trig_o      (trig)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // channel 0 into a known low state, then into mode m
  task automatic setup(input logic [2:0] m, input int b, input int s);
    mode[0] = MD_BYP; raw[0] = 1'b0; syn[0] = 1'b0; inv[0] = 1'b0;
    base[0] = BW'(b); shf[0] = SW'(s);
    tick(3);
    mode[0] = m;
    tick(2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    raw = '0; syn = '0; inv = '0; mode = '0; base = '0; shf = '0;
    inv[3] = 1'b1;
    tick(5);
    chk("R1 inv ch3", trig[3], 1'b1);
    chk("R1 ch0", trig[0], 1'b0);
    rst_n = 1'b1;
    tick(4);
    inv[3] = 1'b0;
    tick(1);
    chk("R1 after release", trig[3], 1'b0);
  endtask

  task automatic t_bypass;
    setup(MD_BYP, 0, 0);
    raw[0] = 1'b1; tick(1);
    chk("R2 rise", trig[0], 1'b1);
    raw[0] = 1'b0; tick(1);
    chk("R2 fall", trig[0], 1'b0);
    mode[0] = 3'd6; tick(2);
    raw[0] = 1'b1; tick(1);
    chk("R2 unused code", trig[0], 1'b1);
  endtask

  task automatic t_sync;
    setup(MD_BYP, 0, 0);
    syn[0] = 1'b1; tick(3);
    raw[0] = 1'b1; tick(2);
    chk("R3 not yet", trig[0], 1'b0);
    tick(1);
    chk("R3 third clock", trig[0], 1'b1);
    syn[0] = 1'b0; raw[0] = 1'b0; tick(3);
  endtask

  task automatic t_invert;
    setup(MD_BYP, 0, 0);
    inv[0] = 1'b1; tick(1);
    chk("R4 low in", trig[0], 1'b1);
    raw[0] = 1'b1; tick(1);
    chk("R4 high in", trig[0], 1'b0);
    inv[0] = 1'b0;
  endtask

  task automatic t_delay;
    setup(MD_DLY, 4, 0);
    raw[0] = 1'b1; tick(3);
    chk("R5 rise held", trig[0], 1'b0);
    tick(1);
    chk("R5 rise passed", trig[0], 1'b1);
    raw[0] = 1'b0; tick(3);
    chk("R5 fall held", trig[0], 1'b1);
    tick(1);
    chk("R5 fall passed", trig[0], 1'b0);
    raw[0] = 1'b1; tick(2);
    raw[0] = 1'b0; tick(6);
    chk("R5 short pulse removed", trig[0], 1'b0);
  endtask

  task automatic t_shift;
    setup(MD_DLY, 3, 2);   // L = 12
    raw[0] = 1'b1; tick(11);
    chk("R6 before 12", trig[0], 1'b0);
    tick(1);
    chk("R6 at 12", trig[0], 1'b1);
  endtask

  task automatic t_restart;
    setup(MD_DLY, 8, 0);
    raw[0] = 1'b1; tick(5);
    raw[0] = 1'b0; tick(1);
    raw[0] = 1'b1; tick(7);
    chk("R10 restarted count", trig[0], 1'b0);
    tick(1);
    chk("R10 full count", trig[0], 1'b1);
  endtask

  task automatic t_rapid;
    setup(MD_RAP, 4, 0);
    raw[0] = 1'b1; tick(1);
    chk("R7 immediate rise", trig[0], 1'b1);
    raw[0] = 1'b0; tick(3);
    chk("R7 locked", trig[0], 1'b1);
    tick(1);
    chk("R7 unlocked fall", trig[0], 1'b0);
    tick(4);
    raw[0] = 1'b1; tick(1);
    raw[0] = 1'b0;
    chk("R7 short pulse passed", trig[0], 1'b1);
  endtask

  task automatic t_sthigh;
    setup(MD_SHI, 5, 0);
    raw[0] = 1'b1; tick(4);
    chk("R8 rise held", trig[0], 1'b0);
    tick(1);
    chk("R8 rise passed", trig[0], 1'b1);
    raw[0] = 1'b0; tick(1);
    chk("R8 fall immediate", trig[0], 1'b0);
  endtask

  task automatic t_stlow;
    setup(MD_SLO, 5, 0);
    raw[0] = 1'b1; tick(1);
    chk("R9 rise immediate", trig[0], 1'b1);
    raw[0] = 1'b0; tick(4);
    chk("R9 fall held", trig[0], 1'b1);
    tick(1);
    chk("R9 fall passed", trig[0], 1'b0);
  endtask

  task automatic t_modechg;
    setup(MD_SHI, 100, 0);
    raw[0] = 1'b1; tick(3);
    chk("R11 pending", trig[0], 1'b0);
    mode[0] = MD_DLY; tick(1);
    chk("R11 resync", trig[0], 1'b1);
  endtask

  task automatic t_indep;
    setup(MD_DLY, 6, 0);
    mode[5] = MD_BYP; raw[5] = 1'b0; tick(2);
    raw[5] = 1'b1; tick(1);
    chk("R12 ch5 follows", trig[5], 1'b1);
    chk("R12 ch0 untouched", trig[0], 1'b0);
    raw[0] = 1'b1; tick(1);
    chk("R12 ch5 unaffected", trig[5], 1'b1);
    chk("R12 ch0 still delayed", trig[0], 1'b0);
    raw[5] = 1'b0; tick(5);
    chk("R12 ch0 delay intact", trig[0], 1'b1);
    chk("R12 ch5 low", trig[5], 1'b0);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_sync();
    t_invert();
    t_delay();
    t_shift();
    t_restart();
    t_rapid();
    t_sthigh();
    t_stlow();
    t_modechg();
    t_indep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule